// File: doc/BRIEF.md
# Snooping Request Router

This block sits between several upstream requesters and several downstream targets. Each cycle it picks at most one upstream request and routes it to a downstream port chosen by the upper address bits. Addresses whose region has no regular target go to a default port, which is numbered after the regular ones. The router drives the source port number along with the request, so that the response path can be steered back to the requester.

When a cacheable request is accepted, the router broadcasts a snoop in the same cycle. The snoop goes to every upstream port registered as a snooper, except the requester. Snoops have no back-pressure. Uncacheable requests are never snooped, and neither is any request while the global bypass input is high.

A single request layer serialises normal traffic. It stays occupied while the data beats of an accepted request pass. A refusal from downstream leaves the layer failed: it stays closed for a header delay and until the refusing target signals a retry. At that point the refused requester gets a one-cycle retry pulse. Express snoop requests skip the layer check and are always accepted.

Top module: `snoop_xbar_router`

## Requirements
- R1: The destination is the address field `addr >> REGION_BITS`. A value k below N_DN selects downstream port k. Any other value selects the default port, whose index is N_DN. At most one `dn_valid` bit is high.
- R2: `dn_src` carries the index of the selected upstream port while `dn_valid` is high.
- R3: An accepted cacheable request raises `snp_valid` in the same cycle for every registered snooping port except the requester, with `snp_addr` equal to the request address.
- R4: An accepted request with `up_uncache` high raises no snoop, and neither does any request while `bypass_mode` is high.
- R5: The snooping set is sampled from `snoop_cfg` during reset. Later changes of `snoop_cfg` have no effect.
- R6: After a normal request with beat count b is accepted (b = 0 counts as 1), normal requests see `up_ready` low for the next b cycles. In the cycle after that, a waiting normal request is accepted.
- R7: If the target holds `dn_ready` low, the normal request is not accepted. Normal requests are then refused for HDR_CYC+1 cycles, and after that until `dn_retry` arrives from that same target, which may arrive early. Retries from other targets are ignored.
- R8: When a failed layer reopens, `up_retry` pulses for one cycle on the refused port only, in the first cycle in which the layer is open again.
- R9: An express request (`up_express`) is accepted whether the layer is open, busy or failed. It drives `dn_express` and leaves the layer's state unchanged.
- R10: Express requests win over normal ones. Among requests of the same kind, the lowest port index wins.
- R11: After reset, with no requests present, `dn_valid`, `up_ready`, `snp_valid` and `up_retry` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; snooping set is sampled while low |
| snoop_cfg | input | N_UP | Snooping port mask, sampled during reset |
| bypass_mode | input | 1 | Global cache bypass: no snoops |
| up_valid | input | N_UP | Request present per upstream port |
| up_addr | input | N_UP*AW | Request address per port, packed |
| up_uncache | input | N_UP | Request is uncacheable |
| up_express | input | N_UP | Request is an express snoop |
| up_beats | input | N_UP*BW | Data beat count per port, packed |
| up_ready | output | N_UP | Request accepted this cycle |
| up_retry | output | N_UP | One-cycle retry notice to a refused port |
| dn_valid | output | N_DN+1 | Request offered to a target (last bit is default) |
| dn_addr | output | AW | Routed address |
| dn_beats | output | BW | Routed beat count |
| dn_src | output | SW | Source upstream port index |
| dn_express | output | 1 | Routed request is express |
| dn_ready | input | N_DN+1 | Target accepts the offered request |
| dn_retry | input | N_DN+1 | Target invites a retry after a refusal |
| snp_valid | output | N_UP | Snoop issued to each upstream port |
| snp_addr | output | AW | Snoop address |

## Verification
On every cycle, the assertions check several properties. Snoops never reach the requester or appear in bypass mode, at most one target is offered a request, and retry pulses are one-hot. They also check that a normal acceptance or a refusal is never followed at once by another normal acceptance, and that a waiting express request is always accepted. Other behaviours show only in the bench's scenarios. These are the exact address decode, the priority order, and the beat-count length of the busy window. They also include the hold-then-retry sequence with early, late and wrong-target retries, and the fact that the snoop mask is sampled only during reset.

// File: rtl/snoop_xbar_router.sv
module snoop_xbar_router #(
  parameter int N_UP        = 3,
  parameter int N_DN        = 2,
  parameter int AW          = 8,
  parameter int REGION_BITS = 6,
  parameter int BW          = 4,
  parameter int HDR_CYC     = 2,
  localparam int N_DST      = N_DN + 1,
  localparam int SW         = (N_UP > 1) ? $clog2(N_UP) : 1,
  localparam int DW         = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UP-1:0]    snoop_cfg,
  input  logic               bypass_mode,
  input  logic [N_UP-1:0]    up_valid,
  input  logic [N_UP*AW-1:0] up_addr,
  input  logic [N_UP-1:0]    up_uncache,
  input  logic [N_UP-1:0]    up_express,
  input  logic [N_UP*BW-1:0] up_beats,
  output logic [N_UP-1:0]    up_ready,
  output logic [N_UP-1:0]    up_retry,
  output logic [N_DST-1:0]   dn_valid,
  output logic [AW-1:0]      dn_addr,
  output logic [BW-1:0]      dn_beats,
  output logic [SW-1:0]      dn_src,
  output logic               dn_express,
  input  logic [N_DST-1:0]   dn_ready,
  input  logic [N_DST-1:0]   dn_retry,
  output logic [N_UP-1:0]    snp_valid,
  output logic [AW-1:0]      snp_addr
);
  localparam int HW = $clog2(HDR_CYC + 1);
  localparam int CW = (HW > BW) ? HW : BW;
  localparam int RW = AW - REGION_BITS;

  typedef enum logic [1:0] {L_OPEN, L_BUSY, L_FAILED} layer_t;

  layer_t          state;
  logic [CW-1:0]   cnt;
  logic            seen;
  logic [DW-1:0]   fail_dst;
  logic [SW-1:0]   fail_src;
  logic [N_UP-1:0] snoop_q;

  logic            sel_ok, sel_exp;
  logic [SW-1:0]   sel;
  logic [AW-1:0]   addr;
  logic [RW-1:0]   region;
  logic [DW-1:0]   dest;
  logic            open_l, accepted, refused, nfire;

  assign open_l = (state == L_OPEN);

  always_comb begin
    sel_ok  = 1'b0;
    sel_exp = 1'b0;
    sel     = '0;
    for (int i = 0; i < N_UP; i++)
      if (!sel_ok && up_valid[i] && up_express[i]) begin
        sel_ok = 1'b1; sel_exp = 1'b1; sel = SW'(i);
      end
    for (int i = 0; i < N_UP; i++)
      if (!sel_ok && open_l && up_valid[i] && !up_express[i]) begin
        sel_ok = 1'b1; sel = SW'(i);
      end
  end

  assign addr   = up_addr[sel*AW +: AW];
  assign region = addr[AW-1:REGION_BITS];
  assign dest   = (region < RW'(N_DN)) ? DW'(region) : DW'(N_DN);

  assign accepted = sel_ok && (sel_exp || dn_ready[dest]);
  assign nfire    = sel_ok && !sel_exp && dn_ready[dest];
  assign refused  = sel_ok && !sel_exp && !dn_ready[dest];

  assign dn_valid   = sel_ok ? (N_DST'(1) << dest) : '0;
  assign dn_addr    = addr;
  assign dn_beats   = up_beats[sel*BW +: BW];
  assign dn_src     = sel;
  assign dn_express = sel_ok && sel_exp;
  assign up_ready   = accepted ? (N_UP'(1) << sel) : '0;

  assign snp_valid = (accepted && !up_uncache[sel] && !bypass_mode)
                   ? (snoop_q & ~(N_UP'(1) << sel)) : '0;
  assign snp_addr  = addr;

  always_ff @(posedge clk)
    if (!rst_n) snoop_q <= snoop_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= L_OPEN;
      cnt      <= '0;
      seen     <= 1'b0;
      fail_dst <= '0;
      fail_src <= '0;
      up_retry <= '0;
    end else begin
      up_retry <= '0;
      case (state)
        L_OPEN: begin
          if (nfire) begin
            state <= L_BUSY;
            cnt   <= (dn_beats == '0) ? CW'(1) : CW'(dn_beats);
          end else if (refused) begin
            state    <= L_FAILED;
            cnt      <= CW'(HDR_CYC);
            seen     <= 1'b0;
            fail_dst <= dest;
            fail_src <= sel;
          end
        end
        L_BUSY: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= L_OPEN;
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (dn_retry[fail_dst]) seen <= 1'b1;
          end else if (seen || dn_retry[fail_dst]) begin
            state              <= L_OPEN;
            up_retry[fail_src] <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/snoop_xbar_router_chk.sv
module snoop_xbar_router_chk #(
  parameter int N_UP  = 3,
  parameter int N_DST = 3,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bypass_mode,
  input logic [N_UP-1:0]  up_valid,
  input logic [N_UP-1:0]  up_express,
  input logic [N_UP-1:0]  up_ready,
  input logic [N_UP-1:0]  up_retry,
  input logic [N_DST-1:0] dn_valid,
  input logic [N_DST-1:0] dn_ready,
  input logic             dn_express,
  input logic [SW-1:0]    dn_src,
  input logic [N_UP-1:0]  snp_valid
);
  logic nacc, nref;
  assign nacc = (|(dn_valid & dn_ready)) && !dn_express;
  assign nref = (|dn_valid) && !(|(dn_valid & dn_ready)) && !dn_express;

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));
  // R3
  snoop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|snp_valid) |-> !snp_valid[dn_src]);
  // R4
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_mode |-> (snp_valid == '0));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nacc |=> !nacc);
  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nref |=> !nacc);
  // R8
  retry_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_retry));
  // R9
  express_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(up_valid & up_express)) |-> (|(up_ready & up_express)));
endmodule

bind snoop_xbar_router snoop_xbar_router_chk #(
  .N_UP(N_UP), .N_DST(N_DST), .SW(SW)
) u_chk (.*);

// File: tb/snoop_xbar_router_tb.sv
module snoop_xbar_router_tb;
  localparam int N_UP = 3, N_DN = 2, AW = 8, BW = 4, N_DST = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_UP-1:0]    snoop_cfg;
  logic               bypass_mode;
  logic [N_UP-1:0]    up_valid, up_uncache, up_express, up_ready, up_retry;
  logic [N_UP*AW-1:0] up_addr;
  logic [N_UP*BW-1:0] up_beats;
  logic [N_DST-1:0]   dn_valid, dn_ready, dn_retry;
  logic [AW-1:0]      dn_addr, snp_addr;
  logic [BW-1:0]      dn_beats;
  logic [1:0]         dn_src;
  logic               dn_express;
  logic [N_UP-1:0]    snp_valid;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  snoop_xbar_router #(.N_UP(N_UP), .N_DN(N_DN), .AW(AW), .REGION_BITS(6),
                      .BW(BW), .HDR_CYC(2)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    up_valid = '0; up_uncache = '0; up_express = '0;
    up_addr = '0; up_beats = '0; dn_retry = '0; dn_ready = '1;
    bypass_mode = 1'b0;
  endtask

  task automatic set_req(int p, logic [7:0] a, bit unc, bit exp, logic [3:0] b);
    up_valid[p] = 1'b1; up_uncache[p] = unc; up_express[p] = exp;
    up_addr[p*AW +: AW] = a; up_beats[p*BW +: BW] = b;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset(logic [2:0] cfg);
    clr();
    snoop_cfg = cfg;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset(3'b111);
    #2;
    check("R11 dn_valid", 32'(dn_valid), 0);
    check("R11 up_ready", 32'(up_ready), 0);
    check("R11 snp_valid", 32'(snp_valid), 0);
    check("R11 up_retry", 32'(up_retry), 0);
  endtask

  task automatic t_decode();
    logic [7:0] al [4] = '{8'h05, 8'h45, 8'h85, 8'hC5};
    int         dl [4] = '{0, 1, 2, 2};
    for (int k = 0; k < 4; k++) begin
      set_req(1, al[k], 1'b0, 1'b0, 4'd1);
      #2;
      check("R1 dest", 32'(dn_valid), 32'(1 << dl[k]));
      check("R2 src", 32'(dn_src), 1);
      check("R1 accept", 32'(up_ready), 32'b010);
      step(); clr(); step();
    end
  endtask

  task automatic t_snoop();
    set_req(1, 8'h10, 1'b0, 1'b0, 4'd1); #2;
    check("R3 snoop set", 32'(snp_valid), 32'b101);
    check("R3 snoop addr", 32'(snp_addr), 32'h10);
    step(); clr(); step();
    set_req(0, 8'h20, 1'b0, 1'b0, 4'd1); #2;
    check("R3 snoop set p0", 32'(snp_valid), 32'b110);
    step(); clr(); step();
    set_req(0, 8'h20, 1'b1, 1'b0, 4'd1); #2;
    check("R4 uncacheable", 32'(snp_valid), 0);
    check("R4 still routed", 32'(up_ready), 32'b001);
    step(); clr(); step();
    bypass_mode = 1'b1;
    set_req(2, 8'h20, 1'b0, 1'b0, 4'd1); #2;
    check("R4 bypass", 32'(snp_valid), 0);
    step(); clr(); step();
  endtask

  task automatic t_busy();
    set_req(0, 8'h00, 1'b0, 1'b0, 4'd3); #2;
    check("R6 first accept", 32'(up_ready), 32'b001);
    step(); clr();
    set_req(1, 8'h40, 1'b0, 1'b0, 4'd1); #2;
    check("R6 busy c1", 32'(up_ready), 0);
    step();
    set_req(2, 8'h80, 1'b0, 1'b1, 4'd1); #2;
    check("R9 express in busy", 32'(up_ready), 32'b100);
    check("R9 express flag", 32'(dn_express), 1);
    step();
    up_valid[2] = 1'b0; up_express[2] = 1'b0; #2;
    check("R6 busy c3", 32'(up_ready), 0);
    step(); #2;
    check("R6 open after beats", 32'(up_ready), 32'b010);
    step(); clr(); step();
  endtask

  task automatic t_prio();
    set_req(0, 8'h00, 1'b0, 1'b0, 4'd1);
    set_req(1, 8'h40, 1'b0, 1'b0, 4'd1); #2;
    check("R10 low index", 32'(up_ready), 32'b001);
    check("R10 src", 32'(dn_src), 0);
    step(); clr(); step();
    set_req(0, 8'h00, 1'b0, 1'b0, 4'd1);
    set_req(2, 8'h40, 1'b0, 1'b1, 4'd1); #2;
    check("R10 express first", 32'(up_ready), 32'b100);
    step();
    up_valid[2] = 1'b0; up_express[2] = 1'b0; #2;
    check("R9 layer untouched", 32'(up_ready), 32'b001);
    step(); clr(); step();
  endtask

  task automatic t_refuse(bit early);
    dn_ready = 3'b110;
    set_req(1, 8'h10, 1'b0, 1'b0, 4'd1); #2;
    check("R7 refused", 32'(up_ready), 0);
    check("R7 offered", 32'(dn_valid), 32'b001);
    step(); dn_ready = '1;
    if (early) dn_retry = 3'b001;
    #2; check("R7 hold c1", 32'(up_ready), 0);
    step(); dn_retry = '0; #2;
    check("R7 hold c2", 32'(up_ready), 0);
    step();
    if (!early) begin
      #2; check("R7 wait retry", 32'(up_ready), 0);
      dn_retry = 3'b010;
      step(); dn_retry = '0; #2;
      check("R7 wrong target ignored", 32'(up_ready), 0);
      check("R8 no pulse", 32'(up_retry), 0);
      dn_retry = 3'b001;
      step(); dn_retry = '0;
    end else begin
      step();
    end
    #2;
    check("R8 retry pulse", 32'(up_retry), 32'b010);
    check("R7 reopened", 32'(up_ready), 32'b010);
    step(); clr(); #2;
    check("R8 pulse one cycle", 32'(up_retry), 0);
    step();
  endtask

  task automatic t_mask();
    do_reset(3'b011);
    snoop_cfg = 3'b111;
    set_req(2, 8'h10, 1'b0, 1'b0, 4'd1); #2;
    check("R5 mask from reset", 32'(snp_valid), 32'b011);
    step(); clr(); step();
    set_req(0, 8'h10, 1'b0, 1'b0, 4'd1); #2;
    check("R5 mask p0", 32'(snp_valid), 32'b010);
    step(); clr(); step();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_snoop();
    t_busy();
    t_prio();
    t_refuse(1'b0);
    t_refuse(1'b1);
    t_mask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule